// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock for a two-channel audio serial link. Both are derived from a free-running module clock. One 32-bit control word sets the block up. It selects whether the block drives the clocks or receives them from the far side, gives one polarity control for each clock, and holds a bit-clock divider code, a frame-length code, a word-size field and a data-format field. In driving mode the block also emits a one-cycle strobe at the start of every frame, for the data serializer that sits beside it.

The bit clock is the module clock divided by one of fourteen ratios between 1 and 192. At ratio 1 the module clock is forwarded as it is. A frame holds 16 to 256 bit periods, always a power of two. The data format decides where the frame clock toggles relative to each channel's first bit. In receiving mode the pad drivers are released, and the external clocks are passed through the same polarity logic to the internal clock outputs. Divider, length and format settings are taken only at a frame boundary, so that no shortened clock pulse ever reaches the pads.

Top module: `aclk_gen`

## Requirements
- R1: Control word fields: bit 15 selects the role (0 = block drives the clocks, 1 = block receives them), bit 14 inverts the bit clock at the pad, bit 13 inverts the frame clock, bits 12:9 are the divider code, bits 8:6 are the frame-length code, bits 5:4 are the word size (1 = 16-bit) and bits 3:2 are the format (0 I2S, 1 left-justified, 2 right-justified, 3 PCM pulse).
- R2: Divider codes 0 to 13 give ratios 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128 and 192. For a ratio R of 2 or more, each bit period lasts R module cycles, and the internal bit clock is low for the first R/2 cycles and high for the last R/2. Codes 14 and 15 act as ratio 1.
- R3: At ratio 1 the internal bit clock equals the module clock: high in the high phase, low in the low phase.
- R4: Frame-length code c gives 2^(c+4) bit periods per frame, and codes 5 to 7 give 256. In driving mode `frame_start` is high for exactly the first module cycle of every frame.
- R5: Internal frame clock 0 marks the left half. In left- and right-justified formats it is 0 for bits 0 to N/2-1 and 1 for the rest. In I2S format it changes one bit earlier: 1 for bits N/2-1 to N-2, and 0 otherwise.
- R6: In PCM format the frame clock is 1 only during bit 0 of each frame.
- R7: In receiving mode both pad enables are low, both pad outputs are 0 and `frame_start` is 0. In driving mode both enables are high.
- R8: In driving mode the pad bit clock is the internal bit clock XOR bit 14, and the pad frame clock is the internal frame clock XOR bit 13 XOR the `POL_FIX` parameter. In receiving mode the internal clocks are the pad inputs XOR the same terms.
- R9: Divider, frame-length and format fields are applied only on the module cycle after a frame's last cycle. After reset the first frame runs at ratio 1, 16 bits, I2S. Role and polarity bits act at once.
- R10: The word-size field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Control word |
| pad_bclk_i | input | 1 | External bit clock (receiving mode) |
| pad_frame_i | input | 1 | External frame clock (receiving mode) |
| pad_bclk_o | output | 1 | Bit clock toward the pad |
| pad_bclk_oe | output | 1 | Bit clock pad drive enable |
| pad_frame_o | output | 1 | Frame clock toward the pad |
| pad_frame_oe | output | 1 | Frame clock pad drive enable |
| core_bclk | output | 1 | Internal bit clock, normal polarity |
| core_frame | output | 1 | Internal frame clock, 0 = left |
| frame_start | output | 1 | One-cycle pulse at the first cycle of a frame |

## Verification
A control-word write that lands in the last cycle of a frame falls in the same cycle as the frame wrap. The new divider and format must then govern the very next bit, while a write one cycle earlier must not. The random phases change the control word at arbitrary cycles, including frame ends. A cycle-level bench model loads the fields only on its own wrap and is compared on every cycle. Role and polarity flips during a frame are provoked the same way and judged at once on the pads.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int CTRL_W   = 32;
  localparam int RATIO_W  = 8;
  localparam int BIT_W    = 8;
  localparam int MODE_BIT = 15;
  localparam int BINV_BIT = 14;
  localparam int FINV_BIT = 13;
  localparam int DIV_LSB  = 9;
  localparam int FRM_LSB  = 6;
  localparam int WSZ_LSB  = 4;
  localparam int FMT_LSB  = 2;
  localparam int MAX_FCODE = 4;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_PCM   = 2'd3
  } fmt_e;

  // divider code to module cycles per bit; reserved codes fall back to 1
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [3:0] code);
    case (code)
      4'd1:    return 8'd2;
      4'd2:    return 8'd4;
      4'd3:    return 8'd6;
      4'd4:    return 8'd8;
      4'd5:    return 8'd12;
      4'd6:    return 8'd16;
      4'd7:    return 8'd24;
      4'd8:    return 8'd32;
      4'd9:    return 8'd48;
      4'd10:   return 8'd64;
      4'd11:   return 8'd96;
      4'd12:   return 8'd128;
      4'd13:   return 8'd192;
      default: return 8'd1;
    endcase
  endfunction

  // frame-length code to bits per frame, clamped at 256
  function automatic logic [BIT_W:0] frame_bits_of(input logic [2:0] code);
    if (code > 3'(MAX_FCODE)) return 9'd256;
    return 9'd16 << code;
  endfunction

  // bit clock level for a divider position: low first half, high second
  function automatic logic bclk_level(input logic [RATIO_W-1:0] pos,
                                      input logic [RATIO_W-1:0] ratio);
    if (ratio == 8'd1) return 1'b0;
    return pos >= (ratio - (ratio >> 1));
  endfunction

  // frame clock level for a bit position in a frame of n bits
  function automatic logic frame_level(input logic [BIT_W-1:0] bpos,
                                       input logic [BIT_W:0] n,
                                       input fmt_e fmt);
    logic [BIT_W:0] b9;
    logic [BIT_W:0] half;
    logic [BIT_W:0] ahead;
    b9    = {1'b0, bpos};
    half  = n >> 1;
    ahead = b9 + 9'd1;
    case (fmt)
      FMT_I2S: return (ahead == n) ? 1'b0 : (ahead >= half);
      FMT_PCM: return (b9 == '0);
      default: return (b9 >= half);
    endcase
  endfunction
endpackage

// File: rtl/aclk_bit_div.sv
module aclk_bit_div
  import aclk_pkg::*;
#(
  parameter int RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] act_ratio,
  input  logic [RW-1:0] nxt_ratio,
  output logic          bit_end,
  output logic          bit_first,
  output logic          bclk_q
);
  logic [RW-1:0] div_q;
  logic [RW-1:0] div_d;

  assign bit_end   = (div_q == act_ratio - RW'(1));
  assign bit_first = (div_q == '0);
  assign div_d     = bit_end ? '0 : div_q + RW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      bclk_q <= bclk_level(div_d, nxt_ratio);
    end
  end

  // R2: a finished bit period restarts the divider
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> bit_first);

  // R2: every divided bit period opens with the clock low
  a_r2_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_first && act_ratio != RW'(1)) |-> !bclk_q);
endmodule

// File: rtl/aclk_frame_seq.sv
module aclk_frame_seq
  import aclk_pkg::*;
#(
  parameter int BW = BIT_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_end,
  input  logic [BW:0] act_bits,
  input  logic [BW:0] nxt_bits,
  input  fmt_e        act_fmt,
  input  fmt_e        nxt_fmt,
  output logic        frame_last,
  output logic        bit_zero,
  output logic        frame_q
);
  logic [BW-1:0] bit_q;
  logic [BW-1:0] bit_d;

  assign frame_last = ({1'b0, bit_q} == act_bits - (BW+1)'(1));
  assign bit_zero   = (bit_q == '0);

  always_comb begin
    bit_d = bit_q;
    if (bit_end) bit_d = frame_last ? '0 : bit_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      frame_q <= 1'b0;
    end else begin
      bit_q   <= bit_d;
      frame_q <= frame_level(bit_d, nxt_bits, nxt_fmt);
    end
  end

  // R4: the last bit of a frame is followed by bit zero
  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && frame_last) |=> bit_zero);

  // R6: the PCM frame marker never extends past bit zero
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fmt == FMT_PCM && frame_q) |-> bit_zero);
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter logic POL_FIX = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              pad_bclk_i,
  input  logic              pad_frame_i,
  output logic              pad_bclk_o,
  output logic              pad_bclk_oe,
  output logic              pad_frame_o,
  output logic              pad_frame_oe,
  output logic              core_bclk,
  output logic              core_frame,
  output logic              frame_start
);
  logic       master;
  logic       binv;
  logic       finv_eff;
  logic [3:0] act_dcode;
  logic [2:0] act_fcode;
  fmt_e       act_fmt;
  logic [3:0] nxt_dcode;
  logic [2:0] nxt_fcode;
  fmt_e       nxt_fmt;
  logic       boundary;
  logic       bit_end;
  logic       bit_first;
  logic       bclk_q;
  logic       frame_last;
  logic       bit_zero;
  logic       frame_q;
  logic       gen_bclk;
  logic [RATIO_W-1:0] act_ratio;
  logic ctrl_unused;

  assign ctrl_unused = ^{ctrl_word[CTRL_W-1:16], ctrl_word[WSZ_LSB +: 2],
                         ctrl_word[1:0]};

  assign master   = ~ctrl_word[MODE_BIT];
  assign binv     = ctrl_word[BINV_BIT];
  assign finv_eff = ctrl_word[FINV_BIT] ^ POL_FIX;

  assign boundary  = bit_end & frame_last;
  assign nxt_dcode = boundary ? ctrl_word[DIV_LSB +: 4] : act_dcode;
  assign nxt_fcode = boundary ? ctrl_word[FRM_LSB +: 3] : act_fcode;
  assign nxt_fmt   = boundary ? fmt_e'(ctrl_word[FMT_LSB +: 2]) : act_fmt;
  assign act_ratio = ratio_of(act_dcode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_dcode <= '0;
      act_fcode <= '0;
      act_fmt   <= FMT_I2S;
    end else begin
      act_dcode <= nxt_dcode;
      act_fcode <= nxt_fcode;
      act_fmt   <= nxt_fmt;
    end
  end

  aclk_bit_div u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_ratio (act_ratio),
    .nxt_ratio (ratio_of(nxt_dcode)),
    .bit_end   (bit_end),
    .bit_first (bit_first),
    .bclk_q    (bclk_q)
  );

  aclk_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_end    (bit_end),
    .act_bits   (frame_bits_of(act_fcode)),
    .nxt_bits   (frame_bits_of(nxt_fcode)),
    .act_fmt    (act_fmt),
    .nxt_fmt    (nxt_fmt),
    .frame_last (frame_last),
    .bit_zero   (bit_zero),
    .frame_q    (frame_q)
  );

  assign gen_bclk     = (act_ratio == RATIO_W'(1)) ? clk : bclk_q;
  assign core_bclk    = master ? gen_bclk : (pad_bclk_i ^ binv);
  assign core_frame   = master ? frame_q : (pad_frame_i ^ finv_eff);
  assign pad_bclk_oe  = master;
  assign pad_frame_oe = master;
  assign pad_bclk_o   = master & (gen_bclk ^ binv);
  assign pad_frame_o  = master & (frame_q ^ finv_eff);
  assign frame_start  = master & bit_first & bit_zero;

  // R9: timing fields move only at a frame boundary
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act_dcode) && $stable(act_fcode) && $stable(act_fmt)));

  // R4: the frame strobe lasts a single module cycle
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: tb/sim_aclk_gen.sv
module sim_aclk_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic POLFIX = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        pad_bclk_i = 1'b0;
  logic        pad_frame_i = 1'b0;
  logic        pad_bclk_o, pad_bclk_oe, pad_frame_o, pad_frame_oe;
  logic        core_bclk, core_frame, frame_start;

  int vectors = 0;
  int fails = 0;
  int m_div = 0, m_bit = 0, m_dc = 0, m_fc = 0, m_fmt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aclk_gen #(.POL_FIX(POLFIX)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .pad_bclk_i(pad_bclk_i), .pad_frame_i(pad_frame_i),
    .pad_bclk_o(pad_bclk_o), .pad_bclk_oe(pad_bclk_oe),
    .pad_frame_o(pad_frame_o), .pad_frame_oe(pad_frame_oe),
    .core_bclk(core_bclk), .core_frame(core_frame), .frame_start(frame_start)
  );

  // ratio table restated as a formula: odd codes 3*2^k, even codes 2^k
  function automatic int b_ratio(input int code);
    if (code == 0 || code > 13) return 1;
    if (code == 1) return 2;
    if (code % 2 == 1) return 3 << ((code - 1) / 2);
    return 1 << (code / 2 + 1);
  endfunction

  function automatic int b_bits(input int fc);
    if (fc > 4) return 256;
    return 16 << fc;
  endfunction

  function automatic logic b_frame(input int b, input int n, input int fmt);
    if (fmt == 3) return (b == 0);
    if (fmt == 0) return (((b + 1) % n) >= n / 2);
    return (b >= n / 2);
  endfunction

  function automatic logic [31:0] mk(input int slave, input int bi, input int fi,
                                     input int dc, input int fc, input int ws,
                                     input int fmt);
    logic [31:0] w;
    w = '0;
    w[15] = slave[0]; w[14] = bi[0]; w[13] = fi[0];
    w[12:9] = dc[3:0]; w[8:6] = fc[2:0]; w[5:4] = ws[1:0]; w[3:2] = fmt[1:0];
    return w;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_now(input string ph);
    int r, n;
    logic g, f, bi, fi;
    r  = b_ratio(m_dc);
    n  = b_bits(m_fc);
    g  = (r == 1) ? 1'b0 : (m_div >= r / 2);
    f  = b_frame(m_bit, n, m_fmt);
    bi = ctrl_word[14];
    fi = ctrl_word[13] ^ POLFIX;
    if (!ctrl_word[15]) begin
      chk({"R2 R3 core_bclk ", ph}, core_bclk, g);
      chk({(m_fmt == 3) ? "R6" : "R5", " core_frame ", ph}, core_frame, f);
      chk({"R4 frame_start ", ph}, frame_start, (m_div == 0 && m_bit == 0));
      chk({"R7 bclk_oe ", ph}, pad_bclk_oe, 1'b1);
      chk({"R7 frame_oe ", ph}, pad_frame_oe, 1'b1);
      chk({"R8 pad_bclk ", ph}, pad_bclk_o, g ^ bi);
      chk({"R8 pad_frame ", ph}, pad_frame_o, f ^ fi);
    end else begin
      chk({"R7 bclk_oe ", ph}, pad_bclk_oe, 1'b0);
      chk({"R7 frame_oe ", ph}, pad_frame_oe, 1'b0);
      chk({"R7 pad_bclk_o ", ph}, pad_bclk_o, 1'b0);
      chk({"R7 pad_frame_o ", ph}, pad_frame_o, 1'b0);
      chk({"R7 frame_start ", ph}, frame_start, 1'b0);
      chk({"R8 core_bclk ", ph}, core_bclk, pad_bclk_i ^ bi);
      chk({"R8 core_frame ", ph}, core_frame, pad_frame_i ^ fi);
    end
  endtask

  // R9: the bench model takes new timing fields only on its own frame wrap
  task automatic model_step();
    int r, n;
    r = b_ratio(m_dc);
    n = b_bits(m_fc);
    if (m_div == r - 1) begin
      m_div = 0;
      if (m_bit == n - 1) begin
        m_bit = 0;
        m_dc  = int'(ctrl_word[12:9]);
        m_fc  = int'(ctrl_word[8:6]);
        m_fmt = int'(ctrl_word[3:2]);
      end else m_bit++;
    end else m_div++;
  endtask

  task automatic run(input int cycles, input string ph, input bit wiggle);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      model_step();
      if (!ctrl_word[15] && b_ratio(m_dc) == 1) begin
        #1;
        chk({"R3 high phase ", ph}, core_bclk, 1'b1);
      end
      @(negedge clk);
      check_now(ph);
      if (wiggle) begin
        pad_bclk_i  = 1'($urandom % 2);
        pad_frame_i = 1'($urandom % 2);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 195000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a1c));
    // R1: fields packed at the stated positions; driving, ratio 12, 32 bits, I2S
    ctrl_word = mk(0, 0, 0, 5, 1, 1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_now("R9 reset state");
    run(16, "R9 first frame", 1'b0);
    run(12 * 32 * 2, "R5 i2s", 1'b0);
    ctrl_word = mk(0, 1, 0, 2, 0, 1, 1);
    run(600, "R5 left", 1'b0);
    ctrl_word = mk(0, 0, 1, 3, 2, 1, 2);
    run(900, "R5 right", 1'b0);
    ctrl_word = mk(0, 1, 1, 1, 0, 1, 3);
    run(400, "R6 pcm", 1'b0);
    ctrl_word = mk(0, 0, 0, 0, 7, 1, 1);
    run(600, "R3 ratio one clamp", 1'b0);
    ctrl_word = mk(0, 1, 0, 14, 0, 1, 0);
    run(100, "R2 reserved 14", 1'b0);
    ctrl_word = mk(0, 0, 0, 15, 5, 1, 3);
    run(600, "R2 reserved 15", 1'b0);
    ctrl_word = mk(0, 0, 0, 4, 0, 2, 0);
    run(300, "R10 size two", 1'b0);
    ctrl_word = mk(0, 0, 0, 4, 0, 3, 0);
    run(300, "R10 size three", 1'b0);
    ctrl_word = mk(1, 1, 0, 6, 0, 1, 1);
    run(300, "R7 receive", 1'b1);
    ctrl_word = mk(1, 0, 1, 6, 0, 1, 1);
    run(300, "R8 receive inv", 1'b1);
    ctrl_word = mk(0, 0, 0, 13, 0, 1, 3);
    run(3400, "R2 ratio 192", 1'b0);
    for (int p = 0; p < 40; p++) begin
      ctrl_word = $urandom;
      run(200 + int'($urandom % 1300), "R9 random", 1'b1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule